// File: doc/BRIEF.md
# Configuration Request Header Generator

This block turns one configuration access command into a configuration request packet on a 64-bit streaming output. A command gives the direction (read or write), the target bus, the device/function byte, a byte offset into configuration space, an access size of 1, 2 or 4 bytes, and the write data. The block works out the byte enables, moves the write data into the byte lanes that the offset selects, and builds the three header doublewords. It then sends them as beats of two 32-bit words, marked with start and end flags, under a valid/ready handshake.

The block holds a root bus number, which resets to 0. A request whose target bus equals it goes out as Type 0, and any other request goes out as Type 1. The requester ID carries this number as well. A write to the root bus's primary bus number register updates it, so the block follows along while software renumbers buses.

Top module: `cfg_req_tlp_gen`

## Requirements
- R1: Header word 0 carries the format/type code in bits 31:24, zeros in bits 23:10 and a length of 1 in bits 9:0. The codes are 0x04 for a Type 0 read, 0x05 for a Type 1 read, 0x44 for a Type 0 write and 0x45 for a Type 1 write. Type 0 is chosen exactly when the target bus equals the stored root bus number.
- R2: Header word 1 has the stored root bus number in bits 31:24, zero in bits 23:16, the tag in bits 15:8 (0x1D for reads, 0x10 for writes), zero in bits 7:4 and the byte enables in bits 3:0.
- R3: Header word 2 has the target bus in bits 31:24, the device/function in bits 23:16 and, in bits 15:0, the offset with its two lowest bits cleared.
- R4: The byte enables are 4'b0001 shifted left by offset[1:0] for size 1 and 4'b0011 shifted left by offset[1:0] (kept to 4 bits) for size 2. Any other size value gives 4'b1111 and is treated as size 4. Write data is masked to its size and shifted left by 8 × offset[1:0] for sizes 1 and 2, is not shifted for size 4, and is kept to 32 bits. Read data is 0.
- R5: Within each 64-bit beat, the first word is in bits 31:0 and the second in bits 63:32. The first beat is {header word 1, header word 0} with the start flag set. For a read, or for a write whose offset[2:0] is nonzero, a second and final beat {data, header word 2} follows with the end flag set. No beat has both flags set.
- R6: A write with offset[2:0] equal to 0 takes three beats: the first beat as in R5, then {0, header word 2} with neither flag, then {0, data} with the end flag.
- R7: While the output valid is high and ready is low, valid, data and both flags hold their values.
- R8: A command is taken only when the command ready output is high. That output is high exactly when no packet is being sent. Command inputs have no effect while a packet is in flight.
- R9: The done output pulses for one cycle, in the cycle after the end beat is accepted, and at no other time.
- R10: The root bus number resets to 0. When a Type 0 write to dword offset 0x18 completes, the root bus number takes bits 7:0 of the lane-aligned write data, and it becomes visible together with done. No other command changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle, command will be taken |
| cmdWrite | input | 1 | 1 = configuration write, 0 = read |
| cmdBus | input | 8 | Target bus number |
| cmdDevFn | input | 8 | Target device/function |
| cmdOffset | input | 12 | Byte offset in configuration space |
| cmdSize | input | 3 | Access size in bytes (1, 2, 4) |
| cmdWrData | input | 32 | Write data, right-justified |
| txValid | output | 1 | Beat present on txData |
| txReady | input | 1 | Downstream takes the beat |
| txData | output | 64 | Beat payload, first word in bits 31:0 |
| txSop | output | 1 | First beat of packet |
| txEop | output | 1 | Last beat of packet |
| cmdDone | output | 1 | One-cycle pulse after the end beat is accepted |
| rootBus | output | 8 | Stored root bus number |

## Verification
The hard case to reach is the change to the root bus number. It needs a Type 0 write, which requires a target bus that matches the current root number, and the write must go to exactly dword 0x18. Only after that write completes does a later command on the new bus go out as Type 0 with the new requester ID. The stimulus first writes a new number through the primary bus register. It then issues reads on the new and the old bus numbers, and follows with near-miss writes (the right offset on another bus, and the right bus at another offset) that must leave the number alone. Meanwhile the ready pattern downstream changes from always-ready to periodic stalls, so that beats are held in the middle of a packet.

// File: rtl/cfgtlp_pkg.sv
package cfgtlp_pkg;

  typedef enum logic [1:0] {
    BEAT_HDR01 = 2'd0,
    BEAT_HDR2  = 2'd1,
    BEAT_DATA  = 2'd2
  } beat_e;

  typedef struct packed {
    logic  load;    // capture the command fields
    logic  commit;  // end beat accepted this cycle
    beat_e beat;    // which beat is on the output
  } ctrl_strobe_t;

  localparam logic [7:0] FMT_RD_T0 = 8'h04;
  localparam logic [7:0] FMT_RD_T1 = 8'h05;
  localparam logic [7:0] FMT_WR_T0 = 8'h44;
  localparam logic [7:0] FMT_WR_T1 = 8'h45;

endpackage

// File: rtl/cfgtlp_ctrl.sv
module cfgtlp_ctrl
  import cfgtlp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         txReady,
  input  logic         threeBeat,
  output ctrl_strobe_t strobe,
  output logic         cmdReady,
  output logic         txValid,
  output logic         cmdDone
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_MID  = 2'd2,
    ST_TAIL = 2'd3
  } state_e;

  state_e state, stateNext;
  logic   accept;
  logic   beatTaken;
  logic   lastBeat;

  assign cmdReady  = (state == ST_IDLE);
  assign txValid   = (state != ST_IDLE);
  assign accept    = cmdValid && cmdReady;
  assign beatTaken = txValid && txReady;
  assign lastBeat  = ((state == ST_MID) && !threeBeat) || (state == ST_TAIL);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept)    stateNext = ST_HDR;
      ST_HDR:  if (beatTaken) stateNext = ST_MID;
      ST_MID:  if (beatTaken) stateNext = threeBeat ? ST_TAIL : ST_IDLE;
      ST_TAIL: if (beatTaken) stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.load   = accept;
    strobe.commit = beatTaken && lastBeat;
    unique case (state)
      ST_MID:  strobe.beat = BEAT_HDR2;
      ST_TAIL: strobe.beat = BEAT_DATA;
      default: strobe.beat = BEAT_HDR01;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmdDone <= 1'b0;
    end else begin
      state   <= stateNext;
      cmdDone <= strobe.commit;
    end
  end

endmodule

// File: rtl/cfgtlp_datapath.sv
module cfgtlp_datapath
  import cfgtlp_pkg::*;
#(
  parameter int         OFFSET_W    = 12,
  parameter logic [7:0] RD_TAG      = 8'h1D,
  parameter logic [7:0] WR_TAG      = 8'h10,
  parameter int         PRI_BUS_OFS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  input  logic                cmdWrite,
  input  logic [7:0]          cmdBus,
  input  logic [7:0]          cmdDevFn,
  input  logic [OFFSET_W-1:0] cmdOffset,
  input  logic [2:0]          cmdSize,
  input  logic [31:0]         cmdWrData,
  output logic [63:0]         beatData,
  output logic                beatSop,
  output logic                beatEop,
  output logic                threeBeat,
  output logic [7:0]          rootBus
);

  localparam int LANES     = 4;
  localparam int HDR_OFS_W = 16;

  // command capture
  logic                isWrite;
  logic [7:0]          tgtBus;
  logic [7:0]          tgtDevFn;
  logic [OFFSET_W-1:0] tgtOffset;
  logic [LANES-1:0]    laneBe;
  logic [31:0]         laneData;

  logic [LANES-1:0]    nextBe;
  logic [1:0]          shiftAmt;
  logic [31:0]         shiftedData;
  logic [31:0]         nextData;

  always_comb begin
    unique case (cmdSize)
      3'd1:    begin nextBe = 4'b0001 << cmdOffset[1:0]; shiftAmt = cmdOffset[1:0]; end
      3'd2:    begin nextBe = 4'b0011 << cmdOffset[1:0]; shiftAmt = cmdOffset[1:0]; end
      default: begin nextBe = 4'b1111;                   shiftAmt = 2'd0;            end
    endcase
    shiftedData = cmdWrData << {shiftAmt, 3'b000};
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign nextData[8*lane +: 8] = (nextBe[lane] && cmdWrite) ? shiftedData[8*lane +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isWrite   <= 1'b0;
      tgtBus    <= '0;
      tgtDevFn  <= '0;
      tgtOffset <= '0;
      laneBe    <= '0;
      laneData  <= '0;
    end else if (strobe.load) begin
      isWrite   <= cmdWrite;
      tgtBus    <= cmdBus;
      tgtDevFn  <= cmdDevFn;
      tgtOffset <= cmdOffset;
      laneBe    <= nextBe;
      laneData  <= nextData;
    end
  end

  // header build
  logic                typeZero;
  logic [7:0]          fmtType;
  logic [OFFSET_W-1:0] alignedOfs;
  logic [31:0]         hdrWord0;
  logic [31:0]         hdrWord1;
  logic [31:0]         hdrWord2;

  assign typeZero   = (tgtBus == rootBus);
  assign alignedOfs = {tgtOffset[OFFSET_W-1:2], 2'b00};
  assign threeBeat  = isWrite && (tgtOffset[2:0] == 3'd0);

  always_comb begin
    unique case ({isWrite, typeZero})
      2'b01:   fmtType = FMT_RD_T0;
      2'b00:   fmtType = FMT_RD_T1;
      2'b11:   fmtType = FMT_WR_T0;
      default: fmtType = FMT_WR_T1;
    endcase
    hdrWord0 = {fmtType, 14'd0, 10'd1};
    hdrWord1 = {rootBus, 8'h00, (isWrite ? WR_TAG : RD_TAG), 4'h0, laneBe};
    hdrWord2 = {tgtBus, tgtDevFn, HDR_OFS_W'(alignedOfs)};
  end

  // beat assembly
  always_comb begin
    beatData = '0;
    beatSop  = 1'b0;
    beatEop  = 1'b0;
    unique case (strobe.beat)
      BEAT_HDR01: begin
        beatData = {hdrWord1, hdrWord0};
        beatSop  = 1'b1;
      end
      BEAT_HDR2: begin
        beatData = {(threeBeat ? 32'd0 : laneData), hdrWord2};
        beatEop  = !threeBeat;
      end
      default: begin
        beatData = {32'd0, laneData};
        beatEop  = 1'b1;
      end
    endcase
  end

  // root bus tracking
  logic hitsPrimary;
  assign hitsPrimary = isWrite && typeZero && (alignedOfs == OFFSET_W'(PRI_BUS_OFS));

  always_ff @(posedge clk) begin
    if (!rstN)                            rootBus <= 8'h00;
    else if (strobe.commit && hitsPrimary) rootBus <= laneData[7:0];
  end

endmodule

// File: rtl/cfg_req_tlp_gen.sv
module cfg_req_tlp_gen
  import cfgtlp_pkg::*;
#(
  parameter int         OFFSET_W    = 12,
  parameter logic [7:0] RD_TAG      = 8'h1D,
  parameter logic [7:0] WR_TAG      = 8'h10,
  parameter int         PRI_BUS_OFS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic                cmdWrite,
  input  logic [7:0]          cmdBus,
  input  logic [7:0]          cmdDevFn,
  input  logic [OFFSET_W-1:0] cmdOffset,
  input  logic [2:0]          cmdSize,
  input  logic [31:0]         cmdWrData,
  output logic                txValid,
  input  logic                txReady,
  output logic [63:0]         txData,
  output logic                txSop,
  output logic                txEop,
  output logic                cmdDone,
  output logic [7:0]          rootBus
);

  ctrl_strobe_t strobe;
  logic         threeBeat;

  cfgtlp_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .txReady   (txReady),
    .threeBeat (threeBeat),
    .strobe    (strobe),
    .cmdReady  (cmdReady),
    .txValid   (txValid),
    .cmdDone   (cmdDone)
  );

  cfgtlp_datapath #(
    .OFFSET_W    (OFFSET_W),
    .RD_TAG      (RD_TAG),
    .WR_TAG      (WR_TAG),
    .PRI_BUS_OFS (PRI_BUS_OFS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdWrite  (cmdWrite),
    .cmdBus    (cmdBus),
    .cmdDevFn  (cmdDevFn),
    .cmdOffset (cmdOffset),
    .cmdSize   (cmdSize),
    .cmdWrData (cmdWrData),
    .beatData  (txData),
    .beatSop   (txSop),
    .beatEop   (txEop),
    .threeBeat (threeBeat),
    .rootBus   (rootBus)
  );

endmodule

// File: rtl/cfgtlp_checker.sv
module cfgtlp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic        txValid,
  input logic        txReady,
  input logic [63:0] txData,
  input logic        txSop,
  input logic        txEop,
  input logic        cmdDone,
  input logic [7:0]  rootBus
);

  assert_hold_beat_R7: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txSop) && $stable(txEop));

  assert_idle_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReady && txValid));

  assert_sop_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> txValid && txSop);

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !(txSop && txEop));

  assert_done_after_eop_R9: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && txEop |=> cmdDone);

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> $past(txValid && txReady && txEop));

  assert_root_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rootBus) |-> $past(txValid && txReady && txEop));

endmodule

bind cfg_req_tlp_gen cfgtlp_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .txValid  (txValid),
  .txReady  (txReady),
  .txData   (txData),
  .txSop    (txSop),
  .txEop    (txEop),
  .cmdDone  (cmdDone),
  .rootBus  (rootBus)
);

// File: tb/cfg_req_tlp_gen_tb.sv
`timescale 1ns/1ps
module cfg_req_tlp_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic        cmdWrite = 1'b0;
  logic [7:0]  cmdBus = '0;
  logic [7:0]  cmdDevFn = '0;
  logic [11:0] cmdOffset = '0;
  logic [2:0]  cmdSize = 3'd4;
  logic [31:0] cmdWrData = '0;
  logic        txValid;
  logic        txReady = 1'b1;
  logic [63:0] txData;
  logic        txSop;
  logic        txEop;
  logic        cmdDone;
  logic [7:0]  rootBus;

  always #2.5 clk = ~clk;

  cfg_req_tlp_gen dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdBus(cmdBus), .cmdDevFn(cmdDevFn), .cmdOffset(cmdOffset),
    .cmdSize(cmdSize), .cmdWrData(cmdWrData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txSop(txSop), .txEop(txEop), .cmdDone(cmdDone), .rootBus(rootBus)
  );

  typedef struct {
    logic [63:0] data;
    logic        sop;
    logic        eop;
    string       tag;
  } beat_t;

  beat_t       expQ[$];
  int          checks = 0;
  int          errors = 0;
  int          doneCount = 0;
  int          cyc = 0;
  int          readyMode = 0;
  logic        expectDone = 1'b0;
  logic [7:0]  modelRoot = 8'h00;
  logic        prevStall = 1'b0;
  logic [65:0] prevBeat = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: builds expected beats from the requirements and issues the command
  task automatic issue(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                       input logic [11:0] off, input logic [2:0] size, input logic [31:0] data,
                       input string tag);
    logic [3:0]  be;
    logic [31:0] mask, wd, h0, h1, h2;
    logic [1:0]  sh;
    logic [7:0]  fmt;
    logic        t0;
    int          d0;
    beat_t       b;
    sh   = (size == 3'd1 || size == 3'd2) ? off[1:0] : 2'd0;
    be   = (size == 3'd1) ? 4'(4'b0001 << off[1:0]) :
           (size == 3'd2) ? 4'(4'b0011 << off[1:0]) : 4'hF;
    mask = (size == 3'd1) ? 32'hFF : (size == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
    wd   = wr ? 32'((data & mask) << (8 * sh)) : 32'd0;
    t0   = (bus == modelRoot);
    fmt  = wr ? (t0 ? 8'h44 : 8'h45) : (t0 ? 8'h04 : 8'h05);
    h0   = {fmt, 24'h000001};
    h1   = {modelRoot, 8'h00, (wr ? 8'h10 : 8'h1D), 4'h0, be};
    h2   = {bus, devfn, 4'h0, off[11:2], 2'b00};
    b.tag = {tag, " R1 R2 R5"}; b.data = {h1, h0}; b.sop = 1'b1; b.eop = 1'b0; expQ.push_back(b);
    if (wr && off[2:0] == 3'd0) begin
      b.tag = {tag, " R3 R6"}; b.data = {32'd0, h2}; b.sop = 1'b0; b.eop = 1'b0; expQ.push_back(b);
      b.tag = {tag, " R4 R6"}; b.data = {32'd0, wd}; b.sop = 1'b0; b.eop = 1'b1; expQ.push_back(b);
    end else begin
      b.tag = {tag, " R3 R4 R5"}; b.data = {wd, h2}; b.sop = 1'b0; b.eop = 1'b1; expQ.push_back(b);
    end
    d0 = doneCount;
    cmdWrite = wr; cmdBus = bus; cmdDevFn = devfn; cmdOffset = off; cmdSize = size; cmdWrData = data;
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    // R8: scrambled command inputs while busy must not alter the packet
    cmdValid = 1'b0; cmdWrite = ~wr; cmdBus = 8'hEE; cmdDevFn = 8'h77;
    cmdOffset = 12'hFFF; cmdSize = 3'd1; cmdWrData = 32'hDEAD_BEEF;
    while (doneCount == d0) @(negedge clk);
    if (wr && t0 && {off[11:2], 2'b00} == 12'h018) modelRoot = wd[7:0];
    chk(rootBus == modelRoot, {tag, " R10 rootBus"}, 64'(rootBus), 64'(modelRoot));
  endtask

  // monitor: downstream ready, beat scoreboard, done and handshake checks
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      case (readyMode)
        1:       txReady = (cyc % 3) != 0;
        2:       txReady = (cyc % 4) == 3;
        default: txReady = 1'b1;
      endcase
      if (prevStall)
        chk(txValid && {txSop, txEop, txData} == prevBeat, "R7 hold while stalled",
            txData, prevBeat[63:0]);
      prevStall = txValid && !txReady;
      prevBeat  = {txSop, txEop, txData};
      if (expectDone) begin
        chk(cmdDone === 1'b1, "R9 done pulse", 64'(cmdDone), 64'd1);
        expectDone = 1'b0;
        doneCount++;
      end else if (cmdDone) begin
        chk(1'b0, "R9 spurious done", 64'd1, 64'd0);
      end
      if (txValid && cmdReady) chk(1'b0, "R8 ready while busy", 64'd1, 64'd0);
      if (txValid && txReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R5 unexpected beat", txData, 64'd0);
        end else begin
          beat_t e;
          e = expQ.pop_front();
          chk(txData == e.data && txSop == e.sop && txEop == e.eop, e.tag,
              {txData[63:2], txSop, txEop}, {e.data[63:2], e.sop, e.eop});
          if (e.eop) expectDone = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rootBus == 8'h00, "R10 reset root", 64'(rootBus), 64'd0);
    chk(cmdReady == 1'b1 && txValid == 1'b0, "R8 reset idle", {cmdReady, txValid}, 64'b10);
    chk(cmdDone == 1'b0, "R9 reset done", 64'(cmdDone), 64'd0);

    readyMode = 0;
    issue(1'b0, 8'h00, 8'h00, 12'h000, 3'd4, 32'h0,          "rd t0 dword");
    issue(1'b0, 8'h03, 8'h08, 12'h00E, 3'd2, 32'h0,          "rd t1 word");
    issue(1'b1, 8'h00, 8'h10, 12'h005, 3'd1, 32'h1234_56AB,  "wr byte unaligned");
    issue(1'b1, 8'h04, 8'h21, 12'h010, 3'd4, 32'hCAFE_F00D,  "wr t1 aligned");
    readyMode = 1;
    issue(1'b1, 8'h00, 8'h00, 12'h018, 3'd4, 32'h0005_0201,  "wr primary bus");
    issue(1'b0, 8'h01, 8'h00, 12'h000, 3'd4, 32'h0,          "rd new root");
    issue(1'b0, 8'h00, 8'h00, 12'h004, 3'd4, 32'h0,          "rd old root");
    readyMode = 2;
    issue(1'b1, 8'h02, 8'h00, 12'h018, 3'd4, 32'h0000_0099,  "wr other bus ofs18");
    issue(1'b1, 8'h01, 8'h00, 12'h01C, 3'd4, 32'h0000_0055,  "wr root ofs1c");
    issue(1'b0, 8'h01, 8'h08, 12'h103, 3'd2, 32'h0,          "rd be trunc");
    issue(1'b1, 8'h01, 8'h00, 12'h01A, 3'd2, 32'h0000_BEEF,  "wr word hi lanes");
    readyMode = 0;
    issue(1'b1, 8'h01, 8'h00, 12'h018, 3'd1, 32'h0000_0007,  "wr primary byte");
    issue(1'b0, 8'h07, 8'hF8, 12'hFFC, 3'd5, 32'h0,          "rd odd size");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R5 all beats seen", 64'(expQ.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule